// File: doc/BRIEF.md
# Operand Addressing Mode Resolver

This block turns one 6-bit operand specifier of a 16-bit, word-addressed processor into an operand value. Where the operand lives in memory, it also gives the effective address. It reads the eight general registers, the stack pointer, the program counter and the overflow register as inputs. It drives a single read port into word memory, which returns data one cycle after the request.

Some modes change the stack pointer or the program counter. For those, the block does not write the registers itself. It outputs the new value together with a one-cycle write strobe, and the surrounding core commits it.

A caller pulses `start` with a specifier while the block is idle and waits for `done`. Register, special-register and short-literal operands finish in the same cycle as `start`. Modes that only read memory finish one cycle later. Modes that first fetch an extra instruction word through the program counter need one or two read cycles. The `is_lit` flag marks operands whose writes the caller must drop.

Top module: `operand_resolver`

## Requirements
- R1: Codes 0x00–0x07 return general register (code & 7) with `done` high in the `start` cycle, no memory read, `is_lit` low and `addr_valid` low.
- R2: Codes 0x1B, 0x1C and 0x1D return `sp_in`, `pc_in` and `ovf_in` respectively in the `start` cycle, with no memory read and no strobe.
- R3: Codes 0x20–0x3F return the zero-extended value (code & 0x1F) in the `start` cycle with `is_lit` high and `addr_valid` low.
- R4: Codes 0x08–0x0F read memory at general register (code & 7) in the `start` cycle. In the next cycle `done` is high, `value` equals the read data, `addr_valid` is high and `eff_addr` is that register value.
- R5: Codes 0x10–0x17 read memory at `pc_in` in the `start` cycle. In the next cycle they read at (read word + register (code & 7)) mod 2^16. One cycle after that, `done` carries the data, that address and `pc_wr` with `pc_next` = `pc_in`+1 mod 2^16.
- R6: Code 0x18 reads memory at `sp_in`, finishes one cycle later with that address and asserts `sp_wr` with `sp_next` = `sp_in`+1 mod 2^16, so 0xFFFF becomes 0x0000.
- R7: Code 0x19 reads memory at `sp_in`, finishes one cycle later with that address and asserts neither `sp_wr` nor `pc_wr`.
- R8: Code 0x1A reads memory at `sp_in`−1 mod 2^16, finishes one cycle later with that address and asserts `sp_wr` with `sp_next` equal to that address, so 0x0000 becomes 0xFFFF.
- R9: Code 0x1E reads the word at `pc_in`, then reads memory at that word. It finishes one cycle later with the data and that address, and asserts `pc_wr` with `pc_in`+1.
- R10: Code 0x1F reads the word at `pc_in` and finishes one cycle later with that word as `value`, `is_lit` high, `addr_valid` low and `pc_wr` with `pc_in`+1.
- R11: While a resolution is in progress, `start`, `spec`, `sp_in`, `pc_in` and the register inputs have no effect on its reads or results. The cycle after `done` shows neither `done` nor a read unless a new `start` arrives.
- R12: `done` is one cycle wide, never coincides with `mem_rd`, and `sp_wr`, `pc_wr`, `addr_valid` and `is_lit` are only ever high together with `done`. After reset the block is idle with all of them low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolving `spec` (accepted only when idle) |
| spec | input | 6 | Operand specifier code |
| gpr_flat | input | 128 | Eight general registers, register i at bits [16i+15:16i] |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Current program counter (points at the next instruction word) |
| ovf_in | input | 16 | Current overflow register |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | Result valid this cycle |
| value | output | 16 | Operand value |
| addr_valid | output | 1 | Operand is a memory location |
| eff_addr | output | 16 | Effective memory address (when `addr_valid`) |
| is_lit | output | 1 | Operand is a literal; writes to it are dropped |
| sp_wr | output | 1 | Commit `sp_next` to the stack pointer |
| sp_next | output | 16 | New stack pointer value |
| pc_wr | output | 1 | Commit `pc_next` to the program counter |
| pc_next | output | 16 | New program counter value |
| busy | output | 1 | A resolution is in progress |

## Verification
The bench builds the block with its default parameters: a 16-bit word and eight general registers. With that width, a stack pointer at 0x0000 or 0xFFFF and a program counter at 0xFFFF reach the wraparound edges of push, pop and next-word fetch. Register values near the top of the range make the indexed sum wrap. All 64 specifier codes run against four register/pointer sets. On alternate sets, `start`, `spec` and the pointers are scrambled while the block is busy, to show the captured state is what counts.

// File: rtl/opr_pkg.sv
package opr_pkg;

  localparam int SPEC_W = 6;
  localparam int SLIT_W = 5;

  typedef enum logic [3:0] {
    AM_REG, AM_SPEC, AM_SLIT, AM_IND, AM_POP,
    AM_PEEK, AM_PUSH, AM_IDX, AM_NWADR, AM_NWLIT
  } am_e;

  typedef enum logic [1:0] {ST_IDLE, ST_NWORD, ST_DATA} st_e;

  function automatic am_e am_of(input logic [SPEC_W-1:0] c);
    am_e m;
    if (c[5]) m = AM_SLIT;
    else begin
      case (c[4:3])
        2'b00: m = AM_REG;
        2'b01: m = AM_IND;
        2'b10: m = AM_IDX;
        default: begin
          case (c[2:0])
            3'd0: m = AM_POP;
            3'd1: m = AM_PEEK;
            3'd2: m = AM_PUSH;
            3'd6: m = AM_NWADR;
            3'd7: m = AM_NWLIT;
            default: m = AM_SPEC;
          endcase
        end
      endcase
    end
    return m;
  endfunction

  // modes that fetch an extra word through the program counter
  function automatic logic am_fetch(input am_e m);
    return (m == AM_IDX) || (m == AM_NWADR) || (m == AM_NWLIT);
  endfunction

  // modes that read memory at an address known in the start cycle
  function automatic logic am_direct_mem(input am_e m);
    return (m == AM_IND) || (m == AM_POP) || (m == AM_PEEK) || (m == AM_PUSH);
  endfunction

  function automatic logic am_moves_sp(input am_e m);
    return (m == AM_POP) || (m == AM_PUSH);
  endfunction

endpackage

// File: rtl/opr_regsel.sv
module opr_regsel #(
  parameter int WORD_W = 16,
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [NREG*WORD_W-1:0] regs_flat,
  input  logic [IDX_W-1:0]       idx,
  output logic [WORD_W-1:0]      val
);
  logic [WORD_W-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign bank[g] = regs_flat[g*WORD_W +: WORD_W];
  end

  assign val = bank[idx];
endmodule

// File: rtl/opr_seq.sv
module opr_seq
  import opr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_fetch,
  input  logic go_mem,
  input  logic lit_fetch,
  output st_e  state
);
  st_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (go_fetch) nxt = ST_NWORD;
                else if (go_mem) nxt = ST_DATA;
      ST_NWORD: nxt = lit_fetch ? ST_IDLE : ST_DATA;
      ST_DATA:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
  import opr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NREG   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [SPEC_W-1:0]      spec,
  input  logic [NREG*WORD_W-1:0] gpr_flat,
  input  logic [WORD_W-1:0]      sp_in,
  input  logic [WORD_W-1:0]      pc_in,
  input  logic [WORD_W-1:0]      ovf_in,
  output logic                   mem_rd,
  output logic [WORD_W-1:0]      mem_addr,
  input  logic [WORD_W-1:0]      mem_rdata,
  output logic                   done,
  output logic [WORD_W-1:0]      value,
  output logic                   addr_valid,
  output logic [WORD_W-1:0]      eff_addr,
  output logic                   is_lit,
  output logic                   sp_wr,
  output logic [WORD_W-1:0]      sp_next,
  output logic                   pc_wr,
  output logic [WORD_W-1:0]      pc_next,
  output logic                   busy
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  function automatic logic [WORD_W-1:0] w_inc(input logic [WORD_W-1:0] a);
    return a + ONE;
  endfunction
  function automatic logic [WORD_W-1:0] w_dec(input logic [WORD_W-1:0] a);
    return a - ONE;
  endfunction
  function automatic logic [WORD_W-1:0] w_add(input logic [WORD_W-1:0] a,
                                              input logic [WORD_W-1:0] b);
    return a + b;
  endfunction

  st_e               state;
  am_e               mode_now, mode_q;
  logic [WORD_W-1:0] gpr_val, ea_now, direct_val, idx_ea;
  logic [WORD_W-1:0] base_q, ea_q, pc_nxt_q, sp_nxt_q;

  // named events
  logic ev_accept, ev_go_fetch, ev_go_mem, ev_lit_fetch;

  assign mode_now     = am_of(spec);
  assign ev_accept    = start && (state == ST_IDLE);
  assign ev_go_fetch  = ev_accept && am_fetch(mode_now);
  assign ev_go_mem    = ev_accept && am_direct_mem(mode_now);
  assign ev_lit_fetch = (mode_q == AM_NWLIT);

  opr_regsel #(.WORD_W(WORD_W), .NREG(NREG)) u_regsel (
    .regs_flat (gpr_flat),
    .idx       (spec[IDX_W-1:0]),
    .val       (gpr_val)
  );

  opr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_fetch  (ev_go_fetch),
    .go_mem    (ev_go_mem),
    .lit_fetch (ev_lit_fetch),
    .state     (state)
  );

  always_comb begin
    unique case (mode_now)
      AM_IND:           ea_now = gpr_val;
      AM_POP, AM_PEEK:  ea_now = sp_in;
      AM_PUSH:          ea_now = w_dec(sp_in);
      default:          ea_now = '0;
    endcase
  end

  always_comb begin
    direct_val = gpr_val;
    if (mode_now == AM_SLIT)
      direct_val = {{(WORD_W-SLIT_W){1'b0}}, spec[SLIT_W-1:0]};
    else if (mode_now == AM_SPEC) begin
      unique case (spec[1:0])
        2'b11:   direct_val = sp_in;
        2'b00:   direct_val = pc_in;
        default: direct_val = ovf_in;
      endcase
    end
  end

  assign idx_ea = w_add(mem_rdata, base_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= AM_REG;
      base_q   <= '0;
      ea_q     <= '0;
      pc_nxt_q <= '0;
      sp_nxt_q <= '0;
    end else if (ev_accept) begin
      mode_q   <= mode_now;
      base_q   <= (mode_now == AM_IDX) ? gpr_val : '0;
      ea_q     <= ea_now;
      pc_nxt_q <= w_inc(pc_in);
      sp_nxt_q <= (mode_now == AM_POP) ? w_inc(sp_in) : w_dec(sp_in);
    end else if (state == ST_NWORD && !ev_lit_fetch) begin
      ea_q     <= idx_ea;
    end
  end

  always_comb begin
    mem_rd     = 1'b0;
    mem_addr   = '0;
    done       = 1'b0;
    value      = '0;
    addr_valid = 1'b0;
    eff_addr   = '0;
    is_lit     = 1'b0;
    sp_wr      = 1'b0;
    pc_wr      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (ev_go_fetch) begin
          mem_rd   = 1'b1;
          mem_addr = pc_in;
        end else if (ev_go_mem) begin
          mem_rd   = 1'b1;
          mem_addr = ea_now;
        end else if (ev_accept) begin
          done   = 1'b1;
          value  = direct_val;
          is_lit = (mode_now == AM_SLIT);
        end
      end
      ST_NWORD: begin
        if (ev_lit_fetch) begin
          done   = 1'b1;
          value  = mem_rdata;
          is_lit = 1'b1;
          pc_wr  = 1'b1;
        end else begin
          mem_rd   = 1'b1;
          mem_addr = idx_ea;
        end
      end
      ST_DATA: begin
        done       = 1'b1;
        value      = mem_rdata;
        addr_valid = 1'b1;
        eff_addr   = ea_q;
        pc_wr      = am_fetch(mode_q);
        sp_wr      = am_moves_sp(mode_q);
      end
      default: ;
    endcase
  end

  assign sp_next = sp_nxt_q;
  assign pc_next = pc_nxt_q;
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/operand_resolver_chk.sv
module operand_resolver_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_rd,
  input logic done,
  input logic addr_valid,
  input logic is_lit,
  input logic sp_wr,
  input logic pc_wr,
  input logic busy
);
  // R12
  done_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && addr_valid |=> !done);

  // R11
  rd_followup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (done || mem_rd));

  // R4
  data_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && addr_valid) |-> $past(mem_rd));

  // R10
  lit_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_lit |-> (done && !addr_valid && !sp_wr));

  // R6
  sp_wr_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |-> (done && addr_valid && !pc_wr));

  // R5
  pc_wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |-> (done && busy));

  // R1
  direct_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !addr_valid && !is_lit) |-> !busy);
endmodule

bind operand_resolver operand_resolver_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_rd     (mem_rd),
  .done       (done),
  .addr_valid (addr_valid),
  .is_lit     (is_lit),
  .sp_wr      (sp_wr),
  .pc_wr      (pc_wr),
  .busy       (busy)
);

// File: tb/sim_operand_resolver.sv
`timescale 1ns/1ps
module sim_operand_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  spec = '0;
  logic [127:0] gpr_flat = '0;
  logic [15:0] sp_in = '0, pc_in = '0, ovf_in = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        done, addr_valid, is_lit, sp_wr, pc_wr, busy;
  logic [15:0] value, eff_addr, sp_next, pc_next;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  operand_resolver u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .spec(spec), .gpr_flat(gpr_flat),
    .sp_in(sp_in), .pc_in(pc_in), .ovf_in(ovf_in), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done), .value(value),
    .addr_valid(addr_valid), .eff_addr(eff_addr), .is_lit(is_lit),
    .sp_wr(sp_wr), .sp_next(sp_next), .pc_wr(pc_wr), .pc_next(pc_next),
    .busy(busy)
  );

  // behavioural memory: contents are a fixed function of the address
  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  function automatic string tag_of(input logic [5:0] c);
    if (c >= 6'h20) return "R3";
    if (c <= 6'h07) return "R1";
    if (c <= 6'h0F) return "R4";
    if (c <= 6'h17) return "R5";
    case (c)
      6'h18: return "R6";
      6'h19: return "R7";
      6'h1A: return "R8";
      6'h1E: return "R9";
      6'h1F: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic cmp(input string tg, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tg, what, act, exp);
    end
  endtask

  function automatic logic [15:0] gpr(input int i);
    return gpr_flat[i*16 +: 16];
  endfunction

  task automatic run_op(input logic [5:0] c, input bit junk);
    int L = 0;
    bit rd [4];
    logic [15:0] ra [4];
    logic [15:0] ev = '0, ea = '0, spn = '0, pcn = '0, nw;
    bit lit = 0, av = 0, spw = 0, pcw = 0;
    logic [15:0] sp0 = sp_in, pc0 = pc_in;
    logic [127:0] g0 = gpr_flat;
    string tg = tag_of(c);
    for (int i = 0; i < 4; i++) begin rd[i] = 0; ra[i] = '0; end
    nw  = memf(pc0);
    pcn = pc0 + 16'd1;
    if (c >= 6'h20) begin ev = {11'd0, c[4:0]}; lit = 1; end
    else if (c <= 6'h07) ev = gpr(int'(c[2:0]));
    else if (c <= 6'h0F) begin
      L = 1; ea = gpr(int'(c[2:0])); rd[0] = 1; ra[0] = ea; av = 1; ev = memf(ea);
    end else if (c <= 6'h17) begin
      L = 2; rd[0] = 1; ra[0] = pc0; ea = nw + gpr(int'(c[2:0]));
      rd[1] = 1; ra[1] = ea; av = 1; ev = memf(ea); pcw = 1;
    end else begin
      case (c)
        6'h18, 6'h19, 6'h1A: begin
          L = 1; ea = (c == 6'h1A) ? sp0 - 16'd1 : sp0;
          rd[0] = 1; ra[0] = ea; av = 1; ev = memf(ea);
          if (c != 6'h19) begin spw = 1; spn = (c == 6'h18) ? sp0 + 16'd1 : ea; end
        end
        6'h1B: ev = sp0;
        6'h1C: ev = pc0;
        6'h1D: ev = ovf_in;
        6'h1E: begin
          L = 2; rd[0] = 1; ra[0] = pc0; ea = nw; rd[1] = 1; ra[1] = ea;
          av = 1; ev = memf(ea); pcw = 1;
        end
        default: begin L = 1; rd[0] = 1; ra[0] = pc0; ev = nw; lit = 1; pcw = 1; end
      endcase
    end

    @(negedge clk);
    spec = c; start = 1'b1;
    for (int k = 0; k <= L + 1; k++) begin
      if (k > 0) begin
        @(negedge clk);
        if (junk && k <= L) begin
          // R11: scrambled inputs while busy
          start = 1'b1; spec = c ^ 6'h15; sp_in = ~sp0; pc_in = ~pc0; gpr_flat = ~g0;
        end else begin
          start = 1'b0; spec = c; sp_in = sp0; pc_in = pc0; gpr_flat = g0;
        end
      end
      #4;
      cmp((k == L + 1) ? "R11" : tg, "done", {15'd0, done}, {15'd0, (k == L)});
      cmp((k == L) ? "R12" : tg, "mem_rd", {15'd0, mem_rd}, {15'd0, rd[k]});
      if (rd[k]) cmp(tg, "mem_addr", mem_addr, ra[k]);
      if (k == L) begin
        cmp(tg, "value", value, ev);
        cmp(tg, "is_lit", {15'd0, is_lit}, {15'd0, lit});
        cmp(tg, "addr_valid", {15'd0, addr_valid}, {15'd0, av});
        if (av) cmp(tg, "eff_addr", eff_addr, ea);
        cmp(tg, "sp_wr", {15'd0, sp_wr}, {15'd0, spw});
        if (spw) cmp(tg, "sp_next", sp_next, spn);
        cmp(tg, "pc_wr", {15'd0, pc_wr}, {15'd0, pcw});
        if (pcw) cmp(tg, "pc_next", pc_next, pcn);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] sps [4];
    logic [15:0] pcs [4];
    sps[0] = 16'h0000; sps[1] = 16'hFFFF; sps[2] = 16'h1234; sps[3] = 16'h8000;
    pcs[0] = 16'hFFFF; pcs[1] = 16'h0100; pcs[2] = 16'h0000; pcs[3] = 16'h7FFE;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #4;
    // R12: idle after reset
    cmp("R12", "reset done", {15'd0, done}, 16'd0);
    cmp("R12", "reset mem_rd", {15'd0, mem_rd}, 16'd0);
    cmp("R12", "reset busy", {15'd0, busy}, 16'd0);
    for (int s = 0; s < 4; s++) begin
      sp_in = sps[s]; pc_in = pcs[s]; ovf_in = 16'hA000 + 16'(s);
      for (int i = 0; i < 8; i++)
        gpr_flat[i*16 +: 16] = 16'hF000 + 16'(s) * 16'h1111 + 16'(i) * 16'h2003;
      for (int c = 0; c < 64; c++) run_op(6'(c), s[0]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule